// File: doc/BRIEF.md
# Single-precision rounding and packing stage

This block accepts a single-precision result that still carries spare low-order bits and turns it into a packed 32-bit word. The inputs are a sign, a biased 8-bit exponent and a 24-bit significand whose bit 23 is the hidden bit. Below the significand sit a guard bit, a round bit and a sticky bit. The block rounds the significand in one of four directions and renormalizes when rounding carries out of the top bit. It saturates to infinity when the exponent runs out of range. It also reports whether any precision was discarded.

The rounding direction is held in a small mode register. That register is written through a one-cycle configuration strobe and resets to round-to-nearest-even. Results leave through a single registered stage with a valid/ready handshake. A producer upstream may push one operand per cycle while the consumer keeps accepting.

Top module: `fp_round_pack`

## Requirements
- R1: After reset, out_valid is 0 and the rounding mode is nearest-even, so the block rounds to nearest-even until cfg_we writes another mode.
- R2: A cycle with cfg_we high loads cfg_mode into the mode register, encoded 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. Later results use that mode.
- R3: In nearest-even mode, a discarded part above half an LSB rounds the magnitude up. A discarded part below half truncates. An exact half (guard 1, round 0, sticky 0) goes to the value whose significand bit 0 is 0.
- R4: In toward-zero mode, the significand is truncated and guard, round and sticky are dropped.
- R5: In toward-+infinity mode, a positive inexact value has its magnitude increased by one LSB. A negative value is truncated.
- R6: In toward--infinity mode, a negative inexact value has its magnitude increased by one LSB. A positive value is truncated.
- R7: When rounding carries out of bit 23, the fraction becomes zero and the exponent rises by one. When an input with exponent 0 rounds up into bit 23, the exponent field becomes 1.
- R8: When the resulting exponent reaches 255, the output is {sign, 8'hFF, 23'h0} and out_overflow is 1. Otherwise out_overflow is 0 and the exponent field is below 255.
- R9: out_inexact is 1 exactly when any of the guard, round or sticky inputs was 1.
- R10: in_ready equals !out_valid | out_ready. The output register loads only on a cycle where in_valid and in_ready are both high. While out_valid is high and out_ready is low, out_word and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the rounding mode |
| cfg_mode | input | 2 | New rounding mode |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Stage can take an operand |
| in_sign | input | 1 | Sign of the operand |
| in_exp | input | 8 | Biased exponent |
| in_sig | input | 24 | Significand, bit 23 hidden bit |
| in_grd | input | 2 | Guard (bit 1) and round (bit 0) bits |
| in_sticky | input | 1 | OR of all lower discarded bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | Packed single-precision result |
| out_inexact | output | 1 | Precision was discarded |
| out_overflow | output | 1 | Result saturated to infinity |

## Verification
A wrong mode register shows up as a wrong LSB or a wrong tie direction on the first inexact operand after the mode write. Random operands reach that case within a few transfers. A broken carry path shows as a fraction of all ones with an unchanged exponent, or as an exponent off by one. A bad saturation shows as an exponent field of 255 with a nonzero fraction. Handshake faults appear in the cycle after a stall, as a lost or duplicated result.

// File: rtl/fp_round_pack.sv
module fp_round_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [SIG_W-1:0]  in_sig,
  input  logic [1:0]        in_grd,
  input  logic              in_sticky,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_inexact,
  output logic              out_overflow
);
  localparam logic [1:0] M_NEAR = 2'b00;
  localparam logic [1:0] M_ZERO = 2'b01;
  localparam logic [1:0] M_POS  = 2'b10;
  localparam logic [1:0] M_NEG  = 2'b11;
  localparam logic [EXP_W:0] E_TOP = (EXP_W+1)'((1 << EXP_W) - 1);

  logic [1:0]       mode;
  logic             lost, bump;
  logic [SIG_W:0]   sum;
  logic [EXP_W:0]   exp_n;
  logic [FRAC_W-1:0] frac_n;
  logic             ovf;
  logic [WORD_W-1:0] word_n;

  assign lost = |in_grd | in_sticky;

  always_comb begin
    unique case (mode)
      M_NEAR:  bump = in_grd[1] & (in_grd[0] | in_sticky | in_sig[0]);
      M_ZERO:  bump = 1'b0;
      M_POS:   bump = lost & ~in_sign;
      M_NEG:   bump = lost & in_sign;
      default: bump = 1'b0;
    endcase
  end

  assign sum = {1'b0, in_sig} + (SIG_W+1)'(bump);

  always_comb begin
    exp_n  = {1'b0, in_exp};
    frac_n = sum[FRAC_W-1:0];
    if (sum[SIG_W]) begin
      exp_n  = {1'b0, in_exp} + 1'b1;
      frac_n = sum[SIG_W-1:1];
    end else if (in_exp == '0 && sum[SIG_W-1]) begin
      exp_n  = (EXP_W+1)'(1);
    end
  end

  assign ovf    = exp_n >= E_TOP;
  assign word_n = ovf ? {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                      : {in_sign, exp_n[EXP_W-1:0], frac_n};

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode         <= M_NEAR;
      out_valid    <= 1'b0;
      out_word     <= '0;
      out_inexact  <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      if (cfg_we) mode <= cfg_mode;
      if (in_valid && in_ready) begin
        out_valid    <= 1'b1;
        out_word     <= word_n;
        out_inexact  <= lost;
        out_overflow <= ovf;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fp_round_pack_chk.sv
module fp_round_pack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        out_inexact,
  input logic        out_overflow
);
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_inexact) && $stable(out_overflow)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_word[30:0] == 31'h7F80_0000); // R8
  AST_NO_FF_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_overflow |-> out_word[30:23] != 8'hFF); // R8
endmodule

bind fp_round_pack fp_round_pack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .out_inexact(out_inexact), .out_overflow(out_overflow)
);

// File: tb/sim_fp_round_pack.sv
module sim_fp_round_pack;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [1:0] cfg_mode = 2'b00, in_grd = 2'b00;
  logic in_sign = 1'b0, in_sticky = 1'b0;
  logic [7:0] in_exp = 8'd0;
  logic [23:0] in_sig = 24'd0;
  logic in_ready, out_valid, out_inexact, out_overflow;
  logic [31:0] out_word;
  int n_chk = 0, n_bad = 0;
  logic [1:0] cur_mode = 2'b00;

  fp_round_pack u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [33:0] model(input logic s, input logic [7:0] e,
      input logic [23:0] sg, input logic [1:0] gr, input logic st, input logic [1:0] m);
    logic [26:0] full;
    logic [2:0]  rem;
    logic [24:0] q;
    logic        inx, up;
    int          ex;
    full = {sg, gr, st};
    rem  = full[2:0];
    inx  = rem != 3'd0;
    case (m)
      2'b00: up = (rem > 3'd4) || (rem == 3'd4 && sg[0]);
      2'b01: up = 1'b0;
      2'b10: up = inx && !s;
      default: up = inx && s;
    endcase
    q  = {1'b0, sg} + {24'd0, up};
    ex = int'(e);
    if (q[24]) begin q = q >> 1; ex = ex + 1; end
    else if (e == 8'd0 && q[23]) ex = 1;
    if (ex >= 255) return {1'b1, inx, s, 8'hFF, 23'd0};
    return {1'b0, inx, s, 8'(ex), q[22:0]};
  endfunction

  task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got ovf=%b inx=%b word=%h, expected ovf=%b inx=%b word=%h",
               req, got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); cfg_we = 1'b1; cfg_mode = m;
    @(negedge clk); cfg_we = 1'b0;
    cur_mode = m;
  endtask

  task automatic drive(input logic s, input logic [7:0] e, input logic [23:0] sg,
                       input logic [1:0] gr, input logic st);
    in_sign = s; in_exp = e; in_sig = sg; in_grd = gr; in_sticky = st;
  endtask

  task automatic send(input string req, input logic s, input logic [7:0] e,
      input logic [23:0] sg, input logic [1:0] gr, input logic st);
    @(negedge clk);
    drive(s, e, sg, gr, st); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_overflow, out_inexact, out_word}, model(s, e, sg, gr, st, cur_mode));
  endtask

  task automatic send_lit(input string req, input logic s, input logic [7:0] e,
      input logic [23:0] sg, input logic [1:0] gr, input logic st, input logic [33:0] lit);
    @(negedge clk);
    drive(s, e, sg, gr, st); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_overflow, out_inexact, out_word}, lit);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [33:0] held;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1", {33'd0, out_valid}, 34'd0);
    rst_n = 1'b1;
    send_lit("R1 R3 tie even", 1'b0, 8'd127, 24'h800002, 2'b10, 1'b0, {2'b01, 32'h3F800002});
    send_lit("R3 tie odd", 1'b0, 8'd127, 24'h800003, 2'b10, 1'b0, {2'b01, 32'h3F800004});
    send_lit("R3 above half", 1'b1, 8'd127, 24'h800002, 2'b10, 1'b1, {2'b01, 32'hBF800003});
    send_lit("R9 exact", 1'b0, 8'd127, 24'h800000, 2'b00, 1'b0, {2'b00, 32'h3F800000});
    send_lit("R9 sticky only", 1'b0, 8'd127, 24'h800000, 2'b00, 1'b1, {2'b01, 32'h3F800000});
    send_lit("R7 carry", 1'b0, 8'd127, 24'hFFFFFF, 2'b11, 1'b0, {2'b01, 32'h40000000});
    send_lit("R7 denorm promote", 1'b0, 8'd0, 24'h7FFFFF, 2'b11, 1'b0, {2'b01, 32'h00800000});
    send_lit("R8 overflow", 1'b0, 8'd254, 24'hFFFFFF, 2'b10, 1'b1, {2'b11, 32'h7F800000});
    set_mode(2'b01);
    send_lit("R2 R4 truncate", 1'b0, 8'd254, 24'hFFFFFF, 2'b11, 1'b1, {2'b01, 32'h7F7FFFFF});
    set_mode(2'b10);
    send_lit("R5 pos up", 1'b0, 8'd128, 24'hC00000, 2'b00, 1'b1, {2'b01, 32'h40400001});
    send_lit("R5 neg trunc", 1'b1, 8'd128, 24'hC00000, 2'b11, 1'b1, {2'b01, 32'hC0400000});
    set_mode(2'b11);
    send_lit("R6 neg up", 1'b1, 8'd127, 24'hF33333, 2'b01, 1'b0, {2'b01, 32'hBFF33334});
    send_lit("R6 pos trunc", 1'b0, 8'd127, 24'hF33333, 2'b11, 1'b0, {2'b01, 32'h3FF33333});
    send_lit("R8 neg overflow", 1'b1, 8'd254, 24'hFFFFFF, 2'b00, 1'b1, {2'b11, 32'hFF800000});

    for (int k = 0; k < 4; k++) begin
      set_mode(2'(k));
      for (int i = 0; i < 150; i++) begin
        logic [7:0] e;
        logic [23:0] sg;
        e  = (i % 10 == 0) ? 8'd254 : 8'($urandom_range(0, 254));
        sg = 24'($urandom);
        if (e != 8'd0) sg[23] = 1'b1; else sg[23] = 1'b0;
        if (i % 7 == 0) sg[22:0] = '1;
        case (k)
          0: send("R3 random", 1'($urandom), e, sg, 2'($urandom), 1'($urandom));
          1: send("R4 random", 1'($urandom), e, sg, 2'($urandom), 1'($urandom));
          2: send("R5 random", 1'($urandom), e, sg, 2'($urandom), 1'($urandom));
          default: send("R6 random", 1'($urandom), e, sg, 2'($urandom), 1'($urandom));
        endcase
      end
    end

    set_mode(2'b00);
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b0, 8'd100, 24'hABCDEF, 2'b00, 1'b0); in_valid = 1'b1;
    @(negedge clk);
    held = model(1'b0, 8'd100, 24'hABCDEF, 2'b00, 1'b0, 2'b00);
    check("R10 first capture", {out_overflow, out_inexact, out_word}, held);
    check("R10 stall ready", {33'd0, in_ready}, 34'd0);
    drive(1'b1, 8'd50, 24'h912345, 2'b10, 1'b1);
    repeat (2) @(negedge clk);
    check("R10 hold under stall", {out_overflow, out_inexact, out_word}, held);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next after stall", {out_overflow, out_inexact, out_word},
          model(1'b1, 8'd50, 24'h912345, 2'b10, 1'b1, 2'b00));
    drive(1'b0, 8'd10, 24'h800000, 2'b00, 1'b0);
    @(negedge clk);
    check("R10 no load without valid", {out_overflow, out_inexact, out_word},
          model(1'b1, 8'd50, 24'h912345, 2'b10, 1'b1, 2'b00));
    check("R10 valid drops", {33'd0, out_valid}, 34'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule